// File: doc/BRIEF.md
# Repeated-Addition Multiplier Sequencer

This block is the control state machine for an 8-bit multiplier datapath. The datapath multiplies by repeated addition. An accumulator A starts at zero. An addend register B holds the first operand, and a down-counter M holds the second operand. Each loop pass adds B into A and decrements M. When M reaches zero, the sequencer forces a zero onto the addend input of the adder, passes A through the adder into the result register R, and signals completion.

The sequencer never sees the operand values. Its only feedback is the datapath's borrow flag `underflow`, which is high when decrementing M would wrap, so it means M is zero. A request is a single-cycle pulse on `req`. A completion is a single-cycle pulse on `done`, in the cycle in which R already holds the product. A second operand of n takes 2n+5 cycles from the request cycle to `done`. All strobes are decoded from the state register alone, so they never depend combinationally on `req` or `underflow`.

Strobe meanings assumed by the datapath:
- `enableAdder` high selects the adder sum onto the A/R input bus; low selects zero.
- `enableZero` high forces the adder's B operand to zero.
- `enableOp1` high loads B from operand 1; low loads zero.
- `selOp2` high loads M from operand 2; low loads M-1.

Top module: `mulSequencer`

## Requirements
- R1: While `nReset` is low, and in the first cycle after it has been low, all eight strobes and `done` are low and the machine is idle; this also holds when reset arrives in the middle of an operation, which is then abandoned.
- R2: While idle with `req` low, every strobe and `done` stay low.
- R3: In the cycle after `req` is sampled high while idle, the strobes are exactly `loadA`, `loadB`, `enableOp1`, `loadM` and `selOp2`, with `enableAdder` low (vector {loadA,loadB,loadM,loadR,enableAdder,enableZero,enableOp1,selOp2} = 8'b1110_0011).
- R4: That cycle is followed by a test cycle with no strobes. If `underflow` is low in a test cycle, the next cycle asserts exactly `loadA`, `enableAdder` and `loadM` with `selOp2` low (8'b1010_1000), and the cycle after that is again a test cycle.
- R5: If `underflow` is high in a test cycle, the next cycle asserts only `loadB`, with `enableOp1` low (8'b0100_0000), so the addend is cleared; a second operand of zero therefore goes straight to this step with no add pass.
- R6: The cycle after the clear asserts exactly `loadR`, `enableAdder` and `enableZero` (8'b0001_1100).
- R7: `done` is high for exactly one cycle, directly after the store cycle, and the machine is idle with no strobes in the following cycle.
- R8: A `req` pulse received while an operation is in progress is ignored: it adds no extra load step and produces no extra `done`.
- R9: With a datapath obeying the strobe meanings above, R holds (operand1 × operand2) mod 256 while `done` is high, and `done` rises 2n+5 cycles after the request cycle, where n is operand 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clock | input | 1 | Rising-edge clock |
| nReset | input | 1 | Asynchronous reset, active low |
| req | input | 1 | One-cycle start pulse |
| underflow | input | 1 | Datapath borrow flag; high when counter M is zero |
| loadA | output | 1 | Load accumulator A |
| loadB | output | 1 | Load addend B |
| loadM | output | 1 | Load counter M |
| loadR | output | 1 | Load result R |
| enableAdder | output | 1 | Select the adder sum (high) or zero (low) onto the A/R bus |
| enableZero | output | 1 | Force the adder's B operand to zero |
| enableOp1 | output | 1 | B loads operand 1 (high) or zero (low) |
| selOp2 | output | 1 | M loads operand 2 (high) or M-1 (low) |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `underflow` truly reflects the counter that the strobes just loaded or decremented, because the branch out of each test cycle is judged against that flag alone. They also assume that `req` is a clean single-cycle pulse. The stimulus meets the first assumption by driving `underflow` from a cycle-accurate datapath model that executes the strobes, rather than toggling the flag freely. It meets the second by raising `req` only for one cycle: either from idle, or deliberately in a busy cycle to exercise the ignore rule.

// File: rtl/mulSeqPkg.sv
package mulSeqPkg;

  // Sequencer states; SIdle must stay the reset state.
  typedef enum logic [2:0] {
    SIdle  = 3'd0,
    SInit  = 3'd1,
    STest  = 3'd2,
    SAdd   = 3'd3,
    SZero  = 3'd4,
    SStore = 3'd5,
    SDone  = 3'd6
  } seqState_t;

  // Strobe bundle from the decoder to the top-level pins.
  typedef struct packed {
    logic loadA;
    logic loadB;
    logic loadM;
    logic loadR;
    logic enableAdder;
    logic enableZero;
    logic enableOp1;
    logic selOp2;
  } strobes_t;

  localparam strobes_t NoStrobes = '0;

endpackage

// File: rtl/mulSeqNext.sv
module mulSeqNext
  import mulSeqPkg::*;
(
  input  logic      clock,
  input  logic      nReset,
  input  logic      req,
  input  logic      underflow,
  output seqState_t state
);

  seqState_t nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      SIdle:   nextState = req ? SInit : SIdle;
      SInit:   nextState = STest;
      STest:   nextState = underflow ? SZero : SAdd;
      SAdd:    nextState = STest;
      SZero:   nextState = SStore;
      SStore:  nextState = SDone;
      SDone:   nextState = SIdle;
      default: nextState = SIdle;
    endcase
  end

  always_ff @(posedge clock or negedge nReset) begin
    if (!nReset) state <= SIdle;
    else         state <= nextState;
  end

endmodule

// File: rtl/mulSeqDecode.sv
module mulSeqDecode
  import mulSeqPkg::*;
(
  input  seqState_t state,
  output strobes_t  strobes,
  output logic      done
);

  // Moore decode: outputs depend on the state register only.
  always_comb begin
    strobes = NoStrobes;
    done    = 1'b0;
    unique case (state)
      SInit: begin
        strobes.loadA     = 1'b1;   // A <= 0 (adder path off)
        strobes.loadB     = 1'b1;
        strobes.enableOp1 = 1'b1;   // B <= operand 1
        strobes.loadM     = 1'b1;
        strobes.selOp2    = 1'b1;   // M <= operand 2
      end
      SAdd: begin
        strobes.loadA       = 1'b1;
        strobes.enableAdder = 1'b1; // A <= A + B
        strobes.loadM       = 1'b1; // M <= M - 1
      end
      SZero: begin
        strobes.loadB = 1'b1;       // B <= 0
      end
      SStore: begin
        strobes.enableZero  = 1'b1;
        strobes.enableAdder = 1'b1;
        strobes.loadR       = 1'b1; // R <= A + 0
      end
      SDone:   done = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/mulSequencer.sv
module mulSequencer
  import mulSeqPkg::*;
(
  input  logic clock,
  input  logic nReset,
  input  logic req,
  input  logic underflow,
  output logic loadA,
  output logic loadB,
  output logic loadM,
  output logic loadR,
  output logic enableAdder,
  output logic enableZero,
  output logic enableOp1,
  output logic selOp2,
  output logic done
);

  seqState_t curState;
  strobes_t  strobeBus;

  mulSeqNext uNext (
    .clock     (clock),
    .nReset    (nReset),
    .req       (req),
    .underflow (underflow),
    .state     (curState)
  );

  mulSeqDecode uDecode (
    .state   (curState),
    .strobes (strobeBus),
    .done    (done)
  );

  assign loadA       = strobeBus.loadA;
  assign loadB       = strobeBus.loadB;
  assign loadM       = strobeBus.loadM;
  assign loadR       = strobeBus.loadR;
  assign enableAdder = strobeBus.enableAdder;
  assign enableZero  = strobeBus.enableZero;
  assign enableOp1   = strobeBus.enableOp1;
  assign selOp2      = strobeBus.selOp2;

endmodule

// File: rtl/mulSeqChecker.sv
module mulSeqChecker
  import mulSeqPkg::*;
(
  input logic      clock,
  input logic      nReset,
  input logic      req,
  input logic      underflow,
  input logic      loadA,
  input logic      loadB,
  input logic      loadM,
  input logic      loadR,
  input logic      enableAdder,
  input logic      enableZero,
  input logic      enableOp1,
  input logic      selOp2,
  input logic      done,
  input seqState_t st
);

  logic [7:0] vec;
  assign vec = {loadA, loadB, loadM, loadR, enableAdder, enableZero, enableOp1, selOp2};

  AST_RESET_QUIET: assert property (@(posedge clock)
    !nReset |=> (vec == 8'h00 && !done)) else $error("reset quiet");            // R1

  AST_IDLE_QUIET: assert property (@(posedge clock) disable iff (!nReset)
    (st == SIdle && !req) |=> (vec == 8'h00 && !done)) else $error("idle quiet"); // R2

  AST_INIT_PATTERN: assert property (@(posedge clock) disable iff (!nReset)
    (st == SIdle && req) |=> (vec == 8'b1110_0011)) else $error("init");          // R3

  AST_ADD_PATTERN: assert property (@(posedge clock) disable iff (!nReset)
    (st == STest && !underflow) |=> (vec == 8'b1010_1000)) else $error("add");    // R4

  AST_CLEAR_PATTERN: assert property (@(posedge clock) disable iff (!nReset)
    (st == STest && underflow) |=> (vec == 8'b0100_0000)) else $error("clear");   // R5

  AST_STORE_PATTERN: assert property (@(posedge clock) disable iff (!nReset)
    loadR |-> (enableZero && enableAdder && !loadA)) else $error("store");         // R6

  AST_DONE_AFTER_STORE: assert property (@(posedge clock) disable iff (!nReset)
    loadR |=> done) else $error("done after store");                              // R7

  AST_DONE_SINGLE: assert property (@(posedge clock) disable iff (!nReset)
    done |=> (!done && vec == 8'h00)) else $error("done width");                  // R7

  AST_BUSY_REQ_IGNORED: assert property (@(posedge clock) disable iff (!nReset)
    (st != SIdle && req) |=> !(loadB && enableOp1)) else $error("busy req");      // R8

endmodule

bind mulSequencer mulSeqChecker uChk (
  .clock       (clock),
  .nReset      (nReset),
  .req         (req),
  .underflow   (underflow),
  .loadA       (loadA),
  .loadB       (loadB),
  .loadM       (loadM),
  .loadR       (loadR),
  .enableAdder (enableAdder),
  .enableZero  (enableZero),
  .enableOp1   (enableOp1),
  .selOp2      (selOp2),
  .done        (done),
  .st          (curState)
);

// File: tb/sim_mulSequencer.sv
module sim_mulSequencer;

  localparam int PeriodNs = 20;

  logic clock = 1'b0;
  logic nReset;
  logic req;
  logic underflow;
  logic loadA, loadB, loadM, loadR, enableAdder, enableZero, enableOp1, selOp2, done;
  logic [7:0] operand1, operand2;
  logic [7:0] dpA, dpB, dpM, dpR;
  int cyc = 0;
  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;
  logic doneLast = 1'b0;

  typedef struct {
    logic [7:0] prod;
    int         due;
  } item_t;
  item_t sbq[$];

  always #(PeriodNs/2) clock = ~clock;
  always @(posedge clock) cyc <= cyc + 1;

  mulSequencer u0 (
    .clock(clock), .nReset(nReset), .req(req), .underflow(underflow),
    .loadA(loadA), .loadB(loadB), .loadM(loadM), .loadR(loadR),
    .enableAdder(enableAdder), .enableZero(enableZero),
    .enableOp1(enableOp1), .selOp2(selOp2), .done(done)
  );

  // Datapath model driven purely by the strobes.
  logic [7:0] sumBus, aBus;
  assign sumBus    = dpA + (enableZero ? 8'h00 : dpB);
  assign aBus      = enableAdder ? sumBus : 8'h00;
  assign underflow = (dpM == 8'h00);

  always @(posedge clock or negedge nReset) begin
    if (!nReset) begin
      dpA <= '0; dpB <= '0; dpM <= '0; dpR <= '0;
    end else begin
      if (loadA) dpA <= aBus;
      if (loadB) dpB <= enableOp1 ? operand1 : 8'h00;
      if (loadM) dpM <= selOp2 ? operand2 : dpM - 8'h01;
      if (loadR) dpR <= aBus;
    end
  end

  function automatic logic [7:0] strb();
    return {loadA, loadB, loadM, loadR, enableAdder, enableZero, enableOp1, selOp2};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Monitor: pops expected items as done pulses appear.
  always @(negedge clock) begin
    if (nReset && done) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R8 unexpected done", 1, 0);
      end else begin
        item_t it;
        it = sbq.pop_front();
        check(dpR == it.prod, "R9 product", dpR, it.prod);
        check(cyc == it.due, "R9 latency", cyc, it.due);
      end
    end
    if (nReset && done && doneLast) check(1'b0, "R7 done width", 2, 1);
    doneLast = done;
  end

  // Driver: one multiplication, optional Req pulse while busy.
  task automatic runOp(input logic [7:0] a, input logic [7:0] b, input bit busyReq);
    item_t it;
    operand1 = a;
    operand2 = b;
    it.prod  = a * b;
    it.due   = cyc + 5 + 2 * int'(b);
    sbq.push_back(it);
    req = 1'b1;
    @(negedge clock); req = 1'b0;
    check(strb() == 8'b1110_0011, "R3 init strobes", strb(), 8'b1110_0011);
    @(negedge clock);
    check(strb() == 8'h00, "R4 test strobes", strb(), 0);
    if (b != 0) begin
      @(negedge clock);
      check(strb() == 8'b1010_1000, "R4 add strobes", strb(), 8'b1010_1000);
      if (busyReq) begin
        @(negedge clock); req = 1'b1;
        @(negedge clock); req = 1'b0;
        check(!(loadB && enableOp1), "R8 no reload", strb(), 0);
      end
    end
    while (cyc < it.due - 2) @(negedge clock);
    check(strb() == 8'b0100_0000, "R5 clear strobes", strb(), 8'b0100_0000);
    @(negedge clock);
    check(strb() == 8'b0001_1100, "R6 store strobes", strb(), 8'b0001_1100);
    @(negedge clock);
    if (busyReq) req = 1'b1;   // Req during the done cycle is ignored as well
    @(negedge clock); req = 1'b0;
    check(strb() == 8'h00 && !done, "R7 idle after done", {done, strb()}, 0);
  endtask

  initial begin
    nReset   = 1'b0;
    req      = 1'b0;
    operand1 = '0;
    operand2 = '0;
    repeat (3) @(negedge clock);
    check(strb() == 8'h00 && !done, "R1 reset outputs", {done, strb()}, 0);
    nReset = 1'b1;
    repeat (3) @(negedge clock);
    check(strb() == 8'h00 && !done, "R2 idle outputs", {done, strb()}, 0);

    runOp(8'd7,   8'd0,   1'b0);  // R5 zero counter
    runOp(8'd0,   8'd9,   1'b0);
    runOp(8'd1,   8'd1,   1'b0);
    runOp(8'd13,  8'd11,  1'b0);
    runOp(8'd20,  8'd17,  1'b0);
    runOp(8'd200, 8'd3,   1'b0);
    runOp(8'd3,   8'd4,   1'b1);  // R8 busy request
    repeat (10) @(negedge clock);
    check(sbq.size() == 0, "R8 no extra op", sbq.size(), 0);
    runOp(8'd255, 8'd255, 1'b0);

    // R1: reset in the middle of an operation abandons it.
    operand1 = 8'd9; operand2 = 8'd6;
    req = 1'b1;
    @(negedge clock); req = 1'b0;
    repeat (5) @(negedge clock);
    nReset = 1'b0;
    #1;
    check(strb() == 8'h00 && !done, "R1 mid-op reset", {done, strb()}, 0);
    @(negedge clock);
    nReset = 1'b1;
    repeat (20) @(negedge clock);
    check(strb() == 8'h00 && !done, "R1 stays idle", {done, strb()}, 0);
    runOp(8'd6, 8'd5, 1'b0);
    repeat (4) @(negedge clock);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    #(PeriodNs * 200000);
    if (!finished) begin
      check(1'b0, "watchdog", cyc, 0);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule